// File: doc/BRIEF.md
# Display Controller Register Bank

This block holds the software-visible control state of a scan-out display controller. A processor reaches it over a simple single-cycle 32-bit register bus. Every register occupies a 16-byte slot, and each slot has four word aliases. The first alias writes the register directly. The second ORs the write data into it. The third clears every bit that is set in the write data. The fourth ignores writes. All four aliases read back the same value, so firmware can set or clear individual control bits without a read-modify-write sequence.

The bank drives its fields straight out to the rest of the controller:
- run, dot-clock mode, clock gate and soft reset,
- bus width and input word length,
- a byte-packing mask,
- a one-cycle FIFO-clear strobe,
- the line and pixel counts of a transfer,
- the frame-buffer address in use.

The frame-buffer address is double-buffered. Software writes the pending address, and the timing generator's frame-start pulse promotes it to current. A stop is graceful. Once software withdraws dot-clock mode or clears run, the run flag stays high until the fetch engine reports an empty pixel FIFO.

Register slots by index (byte address bits 7:4):
- 0: main control
- 1: auxiliary control
- 2: transfer count
- 3: current buffer
- 4: next buffer

Address bits 3:2 choose the alias: 0 direct, 1 set, 2 clear, 3 no-op.

Top module: `disp_ctrl_regs`

## Requirements
- R1: A direct-alias write replaces the writable bits of the addressed register. Non-writable bits and slots with index 5 or above always read 0. Read data is combinational from the address, with or without a write strobe.
- R2: A set-alias write (offset +4) ORs the write data into the writable bits and leaves every other bit unchanged.
- R3: A clear-alias write (offset +8) clears each writable bit that is 1 in the write data. A write at offset +12 changes nothing. All four aliases of a slot read the same value.
- R4: Main control bit layout:
  - bit 31: soft reset
  - bit 30: clock gate
  - bit 17: dot-clock mode
  - bits 11:10: bus width
  - bits 9:8: word length
  - bit 0: run

  Each field appears on its output port from the cycle after the write.
- R5: Auxiliary control holds the byte-packing mask in bits 19:16. Writing a 1 to bit 21 through the direct or set alias raises fifo_clear_o for exactly the one cycle after the write edge. Bit 21 always reads 0. A clear-alias write of bit 21 produces no pulse.
- R6: Transfer count is a full 32-bit register. Bits 31:16 drive line_count_o and bits 15:0 drive line_pixels_o.
- R7: While run is 1, each of the following starts a drain:
  - clearing dot-clock mode,
  - clearing run,
  - setting run while dot-clock mode is 0.

  During a drain, run stays 1 and further run writes are ignored. Run falls at the first later clock edge at which fifo_empty_i is high.
- R8: The next-buffer slot is a 32-bit read/write register. At every edge where frame_start_i is high, the current buffer loads the next-buffer value held before that edge. A next-buffer write at the same edge is kept for the following frame.
- R9: The current-buffer slot is read-only. Writes through any alias leave it unchanged.
- R10: While soft reset is 1, the following are forced to zero in the same edge that sets soft reset:
  - every other control bit, including run,
  - the packing mask,
  - transfer count,
  - both buffer addresses.

  Writes to those registers are ignored and no FIFO-clear pulse is issued. A main-control write that leaves bit 31 at 0 releases the bank.
- R11: After the reset input is released, every register reads 0 and every output port is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W | Byte address: slot index in bits ADDR_W-1:4, alias in bits 3:2 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed slot |
| fifo_empty_i | input | 1 | Pixel FIFO reports empty |
| frame_start_i | input | 1 | Frame-boundary pulse from the timing generator |
| run_o | output | 1 | Controller running |
| dotclk_mode_o | output | 1 | Dot-clock mode enabled |
| clk_gate_o | output | 1 | Clock gate request |
| soft_reset_o | output | 1 | Soft reset held |
| bus_width_o | output | 2 | Display bus-width code |
| word_len_o | output | 2 | Input word-length code |
| pack_mask_o | output | 4 | Byte-packing mask |
| fifo_clear_o | output | 1 | One-cycle FIFO-clear strobe |
| line_count_o | output | 16 | Lines per transfer |
| line_pixels_o | output | 16 | Pixels per line |
| cur_buf_o | output | 32 | Frame-buffer address in use |

## Verification
The following properties are checked on every cycle:
- Run can only fall after an empty FIFO was seen, or under soft reset.
- The current buffer changes only after a frame-start pulse.
- The FIFO-clear strobe only follows a bus write.
- Soft reset keeps run, the packing mask, the current buffer and the strobe at zero.
- The FIFO-clear bit never reads back as 1.

The arithmetic of the set and clear aliases, the alias read equivalence, field placement and the ordering between a frame-start pulse and a simultaneous write can only be shown by the bench's sweeps and directed scenarios.

// File: rtl/disp_ctrl_regs_pkg.sv
package disp_ctrl_regs_pkg;

  localparam int DW       = 32;
  localparam int NUM_REGS = 5;
  localparam int IDX_W    = 3;

  localparam int IDX_MAIN = 0;
  localparam int IDX_AUX  = 1;
  localparam int IDX_XFER = 2;
  localparam int IDX_CUR  = 3;
  localparam int IDX_NEXT = 4;

  // main control bit positions
  localparam int B_SRST   = 31;
  localparam int B_CKGATE = 30;
  localparam int B_DOTCLK = 17;
  localparam int B_BUSW   = 10;
  localparam int B_WLEN   = 8;
  localparam int B_RUN    = 0;

  // auxiliary control bit positions
  localparam int B_FCLR   = 21;
  localparam int B_PACK   = 16;

  localparam logic [DW-1:0] MAIN_MASK = 32'hC002_0F01;
  localparam logic [DW-1:0] AUX_MASK  = 32'h000F_0000;
  localparam logic [DW-1:0] FULL_MASK = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    ALIAS_WR   = 2'd0,
    ALIAS_SET  = 2'd1,
    ALIAS_CLR  = 2'd2,
    ALIAS_NONE = 2'd3
  } alias_e;

  function automatic logic [DW-1:0] alias_merge(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] wdata,
                                                input logic [DW-1:0] mask,
                                                input alias_e op);
    logic [DW-1:0] m;
    m = wdata & mask;
    case (op)
      ALIAS_WR:  return m;
      ALIAS_SET: return (cur & mask) | m;
      ALIAS_CLR: return (cur & mask) & ~m;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import disp_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  output logic [NUM_REGS-1:0]  wr_hit_o,
  output alias_e               op_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic                 rd_known_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic              wr_any;
  logic              unused_low;

  assign slot       = bus_addr_i[ADDR_W-1:4];
  assign op_o       = alias_e'(bus_addr_i[3:2]);
  assign unused_low = ^bus_addr_i[1:0];
  assign wr_any     = bus_valid_i && bus_write_i && (op_o != ALIAS_NONE);
  assign rd_known_o = (int'(slot) < NUM_REGS);
  assign rd_idx_o   = slot[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign wr_hit_o[g] = wr_any && (int'(slot) == g);
  end
endmodule

// File: rtl/dcr_word.sv
module dcr_word
  import disp_ctrl_regs_pkg::*;
#(
  parameter logic [DW-1:0] MASK = FULL_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  alias_e        op_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] d;

  always_comb begin
    if (clr_i)     d = '0;
    else if (wr_i) d = alias_merge(q_o, wdata_i, MASK, op_i);
    else           d = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d;
  end
endmodule

// File: rtl/dcr_main.sv
module dcr_main
  import disp_ctrl_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  alias_e        op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          fifo_empty_i,
  output logic [DW-1:0] q_o,
  output logic          srst_nxt_o
);
  logic [DW-1:0] nv, d;
  logic          drain_q, drain_d;
  logic          stop_req;

  assign nv         = wr_i ? alias_merge(q_o, wdata_i, MAIN_MASK, op_i) : q_o;
  assign srst_nxt_o = nv[B_SRST];
  assign stop_req   = (q_o[B_RUN] && !nv[B_RUN]) ||
                      (nv[B_RUN] && !nv[B_DOTCLK]);

  always_comb begin
    d       = nv;
    drain_d = drain_q;
    if (nv[B_SRST]) begin
      d         = '0;
      d[B_SRST] = 1'b1;
      drain_d   = 1'b0;
    end else if (drain_q) begin
      d[B_RUN] = !fifo_empty_i;
      drain_d  = !fifo_empty_i;
    end else if (stop_req) begin
      d[B_RUN] = 1'b1;
      drain_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o     <= '0;
      drain_q <= 1'b0;
    end else begin
      q_o     <= d;
      drain_q <= drain_d;
    end
  end
endmodule

// File: rtl/dcr_aux.sv
module dcr_aux
  import disp_ctrl_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  alias_e        op_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic          fifo_clear_o
);
  logic pulse_d;

  assign pulse_d = wr_i && !clr_i && (op_i != ALIAS_CLR) && wdata_i[B_FCLR];

  dcr_word #(.MASK(AUX_MASK)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .wr_i    (wr_i),
    .op_i    (op_i),
    .wdata_i (wdata_i),
    .q_o     (q_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_clear_o <= 1'b0;
    else        fifo_clear_o <= pulse_d;
  end
endmodule

// File: rtl/dcr_bufswap.sv
module dcr_bufswap
  import disp_ctrl_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_next_i,
  input  alias_e        op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          frame_start_i,
  output logic [DW-1:0] next_o,
  output logic [DW-1:0] cur_o
);
  logic [DW-1:0] cur_d;

  dcr_word #(.MASK(FULL_MASK)) u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .wr_i    (wr_next_i),
    .op_i    (op_i),
    .wdata_i (wdata_i),
    .q_o     (next_o)
  );

  always_comb begin
    if (clr_i)              cur_d = '0;
    else if (frame_start_i) cur_d = next_o;
    else                    cur_d = cur_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_o <= '0;
    else        cur_o <= cur_d;
  end
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              fifo_empty_i,
  input  logic              frame_start_i,
  output logic              run_o,
  output logic              dotclk_mode_o,
  output logic              clk_gate_o,
  output logic              soft_reset_o,
  output logic [1:0]        bus_width_o,
  output logic [1:0]        word_len_o,
  output logic [3:0]        pack_mask_o,
  output logic              fifo_clear_o,
  output logic [15:0]       line_count_o,
  output logic [15:0]       line_pixels_o,
  output logic [31:0]       cur_buf_o
);
  logic [NUM_REGS-1:0] wr_hit;
  alias_e              op;
  logic [IDX_W-1:0]    rd_idx;
  logic                rd_known;
  logic                srst_nxt;
  logic [DW-1:0]       main_q, aux_q, xfer_q, next_q, cur_q;
  logic [DW-1:0]       rd_vals [NUM_REGS];

  dcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .wr_hit_o    (wr_hit),
    .op_o        (op),
    .rd_idx_o    (rd_idx),
    .rd_known_o  (rd_known)
  );

  dcr_main u_main (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr_hit[IDX_MAIN]),
    .op_i         (op),
    .wdata_i      (bus_wdata_i),
    .fifo_empty_i (fifo_empty_i),
    .q_o          (main_q),
    .srst_nxt_o   (srst_nxt)
  );

  dcr_aux u_aux (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (srst_nxt),
    .wr_i         (wr_hit[IDX_AUX]),
    .op_i         (op),
    .wdata_i      (bus_wdata_i),
    .q_o          (aux_q),
    .fifo_clear_o (fifo_clear_o)
  );

  dcr_word #(.MASK(FULL_MASK)) u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (srst_nxt),
    .wr_i    (wr_hit[IDX_XFER]),
    .op_i    (op),
    .wdata_i (bus_wdata_i),
    .q_o     (xfer_q)
  );

  dcr_bufswap u_buf (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (srst_nxt),
    .wr_next_i     (wr_hit[IDX_NEXT]),
    .op_i          (op),
    .wdata_i       (bus_wdata_i),
    .frame_start_i (frame_start_i),
    .next_o        (next_q),
    .cur_o         (cur_q)
  );

  logic unused_cur_hit;
  assign unused_cur_hit = wr_hit[IDX_CUR];

  always_comb begin
    rd_vals[IDX_MAIN] = main_q;
    rd_vals[IDX_AUX]  = aux_q;
    rd_vals[IDX_XFER] = xfer_q;
    rd_vals[IDX_CUR]  = cur_q;
    rd_vals[IDX_NEXT] = next_q;
    bus_rdata_o       = rd_known ? rd_vals[rd_idx] : '0;
  end

  assign run_o         = main_q[B_RUN];
  assign dotclk_mode_o = main_q[B_DOTCLK];
  assign clk_gate_o    = main_q[B_CKGATE];
  assign soft_reset_o  = main_q[B_SRST];
  assign bus_width_o   = main_q[B_BUSW+1:B_BUSW];
  assign word_len_o    = main_q[B_WLEN+1:B_WLEN];
  assign pack_mask_o   = aux_q[B_PACK+3:B_PACK];
  assign line_count_o  = xfer_q[31:16];
  assign line_pixels_o = xfer_q[15:0];
  assign cur_buf_o     = cur_q;
endmodule

// File: rtl/disp_ctrl_regs_chk.sv
module disp_ctrl_regs_chk
  import disp_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic              fifo_empty_i,
  input logic              frame_start_i,
  input logic              run_o,
  input logic              soft_reset_o,
  input logic [3:0]        pack_mask_o,
  input logic              fifo_clear_o,
  input logic [31:0]       cur_buf_o
);
  // R7: run only falls after an empty FIFO was sampled, or under soft reset
  assert_run_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> ($past(fifo_empty_i) || soft_reset_o));

  // R8: the current buffer moves only after a frame-start pulse (or soft reset)
  assert_cur_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_buf_o) |-> ($past(frame_start_i) || soft_reset_o));

  // R5: the FIFO-clear strobe only follows a bus write
  assert_fifo_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear_o |-> $past(bus_valid_i && bus_write_i));

  // R5: the FIFO-clear bit never reads back as 1
  assert_fclr_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr_i[ADDR_W-1:4]) == IDX_AUX) |-> !bus_rdata_o[B_FCLR]);

  // R10: soft reset holds the bank at zero
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_o |-> (!run_o && pack_mask_o == 4'd0 && cur_buf_o == 32'd0 && !fifo_clear_o));
endmodule

bind disp_ctrl_regs disp_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid_i   (bus_valid_i),
  .bus_write_i   (bus_write_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rdata_o   (bus_rdata_o),
  .fifo_empty_i  (fifo_empty_i),
  .frame_start_i (frame_start_i),
  .run_o         (run_o),
  .soft_reset_o  (soft_reset_o),
  .pack_mask_o   (pack_mask_o),
  .fifo_clear_o  (fifo_clear_o),
  .cur_buf_o     (cur_buf_o)
);

// File: tb/disp_ctrl_regs_tb.sv
module disp_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        fifo_empty_i = 1'b1, frame_start_i = 1'b0;
  logic        run_o, dotclk_mode_o, clk_gate_o, soft_reset_o, fifo_clear_o;
  logic [1:0]  bus_width_o, word_len_o;
  logic [3:0]  pack_mask_o;
  logic [15:0] line_count_o, line_pixels_o;
  logic [31:0] cur_buf_o;

  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  disp_ctrl_regs u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int op, input logic [31:0] d);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1;
    bus_addr_i  = {idx[3:0], op[1:0], 2'b00};
    bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic rd(input int idx, input int op, output logic [31:0] q);
    bus_addr_i = {idx[3:0], op[1:0], 2'b00};
    #1 q = bus_rdata_o;
  endtask

  function automatic logic [31:0] model(input logic [31:0] cur, d, mask, input int op);
    case (op)
      0: return d & mask;
      1: return cur | (d & mask);
      2: return cur & ~(d & mask);
      default: return cur;
    endcase
  endfunction

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] q, m, pat;
    int    sidx[4];
    logic [31:0] smask[4];
    sidx  = '{0, 1, 2, 4};
    smask = '{32'h4002_0F00, 32'h000F_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int i = 0; i < 5; i++) begin
      rd(i, 0, q); chk("R11 reset read", q, 32'h0);
    end
    chk("R11 reset outputs", {run_o, dotclk_mode_o, clk_gate_o, soft_reset_o, fifo_clear_o,
        bus_width_o, word_len_o, pack_mask_o}, 32'h0);
    chk("R11 reset buffer", cur_buf_o, 32'h0);

    // R1 R2 R3 alias sweep
    for (int r = 0; r < 4; r++) begin
      m = '0;
      for (int p = 0; p < 8; p++) begin
        for (int op = 0; op < 4; op++) begin
          pat = (32'h9E37_79B9 * (p * 4 + op + 1)) ^ (32'h0F0F_3C3C << p);
          wr(sidx[r], op, pat & smask[r]);
          m = model(m, pat, smask[r], op);
          rd(sidx[r], (p + op) % 4, q);
          case (op)
            0: chk("R1 direct write", q, m);
            1: chk("R2 set alias", q, m);
            default: chk("R3 clear/no-op alias", q, m);
          endcase
          if (r == 0)
            chk("R4 field ports", {20'd0, clk_gate_o, dotclk_mode_o, bus_width_o, word_len_o, 6'd0},
                {20'd0, m[30], m[17], m[11:10], m[9:8], 6'd0});
          if (r == 2)
            chk("R6 count ports", {line_count_o, line_pixels_o}, m);
        end
      end
    end
    rd(7, 0, q); chk("R1 unmapped slot", q, 32'h0);

    // R9 current buffer read-only
    wr(3, 0, 32'hDEAD_BEEF);
    wr(3, 1, 32'hFFFF_FFFF);
    rd(3, 0, q); chk("R9 cur read-only", q, 32'h0);

    // R5 fifo clear pulse
    wr(1, 0, 32'h0005_0000);
    wr(1, 1, 32'h0020_0000);
    chk("R5 pulse high", {31'd0, fifo_clear_o}, 32'd1);
    rd(1, 0, q); chk("R5 bit21 reads 0, mask kept", q, 32'h0005_0000);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, fifo_clear_o}, 32'd0);
    wr(1, 2, 32'h0020_0000);
    chk("R5 clear alias no pulse", {31'd0, fifo_clear_o}, 32'd0);

    // R8 double buffering
    wr(4, 0, 32'h1000_0000);
    chk("R8 no swap yet", cur_buf_o, 32'h0);
    @(negedge clk); frame_start_i = 1'b1;
    @(negedge clk); frame_start_i = 1'b0;
    chk("R8 swap at frame start", cur_buf_o, 32'h1000_0000);
    wr(4, 0, 32'h2000_0000);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = {4'd4, 4'd0};
    bus_wdata_i = 32'h3000_0000; frame_start_i = 1'b1;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; frame_start_i = 1'b0;
    chk("R8 simultaneous: cur gets old next", cur_buf_o, 32'h2000_0000);
    rd(4, 0, q); chk("R8 simultaneous: next kept", q, 32'h3000_0000);

    // R7 graceful stop by clearing dot-clock mode
    wr(0, 0, 32'h0002_0000);
    wr(0, 1, 32'h0000_0001);
    chk("R7 run set", {31'd0, run_o}, 32'd1);
    fifo_empty_i = 1'b0;
    wr(0, 2, 32'h0002_0000);
    repeat (3) @(negedge clk);
    chk("R7 run held while FIFO busy", {31'd0, run_o}, 32'd1);
    wr(0, 1, 32'h0000_0001);
    chk("R7 run held after run write", {31'd0, run_o}, 32'd1);
    fifo_empty_i = 1'b1;
    @(negedge clk);
    chk("R7 run drops after drain", {31'd0, run_o}, 32'd0);
    rd(0, 0, q); chk("R7 run bit reads 0", q & 32'h1, 32'h0);

    // R7 graceful stop by clearing run
    wr(0, 1, 32'h0002_0001);
    fifo_empty_i = 1'b0;
    wr(0, 2, 32'h0000_0001);
    @(negedge clk);
    chk("R7 run clear held", {31'd0, run_o}, 32'd1);
    fifo_empty_i = 1'b1;
    @(negedge clk);
    chk("R7 run clear completes", {31'd0, run_o}, 32'd0);

    // R7 run set without dot-clock mode
    wr(0, 2, 32'h0002_0000);
    fifo_empty_i = 1'b0;
    wr(0, 1, 32'h0000_0001);
    @(negedge clk);
    chk("R7 run without mode held", {31'd0, run_o}, 32'd1);
    fifo_empty_i = 1'b1;
    @(negedge clk);
    chk("R7 run without mode drops", {31'd0, run_o}, 32'd0);

    // R10 soft reset
    wr(0, 1, 32'h4002_0501);
    wr(1, 0, 32'h000A_0000);
    wr(2, 0, 32'h0100_0200);
    wr(0, 1, 32'h8000_0000);
    rd(0, 1, q); chk("R10 main forced", q, 32'h8000_0000);
    rd(1, 0, q); chk("R10 aux cleared", q, 32'h0);
    rd(2, 0, q); chk("R10 xfer cleared", q, 32'h0);
    rd(4, 0, q); chk("R10 next cleared", q, 32'h0);
    chk("R10 cur cleared", cur_buf_o, 32'h0);
    wr(4, 0, 32'h5555_0000);
    wr(1, 1, 32'h0020_0000);
    chk("R10 no pulse in soft reset", {31'd0, fifo_clear_o}, 32'd0);
    rd(4, 0, q); chk("R10 writes ignored", q, 32'h0);
    wr(0, 2, 32'h8000_0000);
    chk("R10 released", {31'd0, soft_reset_o}, 32'd0);
    wr(4, 0, 32'h5555_0000);
    rd(4, 0, q); chk("R10 writable again", q, 32'h5555_0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule